// File: doc/BRIEF.md
# Bus-Addressed Dual Parallel Port

This block is a bus slave that gives a host two 8-bit parallel ports, A and B. Each line of each port can be an input or an output. Every port has three registers: a direction register, an output latch, and a control register. The host sees only four addresses. Because of this, a port's direction register and its output latch share one address, and a select bit in that port's control register decides which one of the two is reached.

The host side is synchronous to `clk`. A transfer happens on each rising clock edge where the enable strobe is high and the chip-select pattern is valid. A write takes the host data at that edge. During a selected, enabled read the host data bus is driven with the addressed value.

The two ports read back output lines from different places:
- A port A read returns the pad levels on every bit.
- A port B read returns the output latch on its output bits.

Pads are modelled as separate in, out and output-enable vectors. Interrupt logic lives outside this block. It supplies two status flags per port, which show in the top bits of the control register. The block gives that logic a one-cycle strobe after each read of a port's output-latch location.

Top module: `par_port_slave`

## Requirements
- R1: The block is selected only while `cs_a`=1, `cs_b`=1 and `cs_n`=0. When it is not selected, a write changes no register and a read does not drive the bus (`host_rdata_oe`=0).
- R2: A write takes `host_wdata` at the rising `clk` edge where `en`=1, `rd_wr`=0 and the block is selected. `host_rdata_oe` is 1 exactly while `en`=1, `rd_wr`=1 and the block is selected. During that time `host_rdata` carries the addressed value in the same cycle.
- R3: Each direction register bit drives the matching `p?_oe` bit, where 1 means output and 0 means input. The output latch drives `p?_out` on all bits.
- R4: At the shared port address, control bit 2 = 1 selects the output latch and control bit 2 = 0 selects the direction register, for both writes and reads.
- R5: `rst_n`=0 clears all registers asynchronously. Every line becomes an input, every latch becomes 0, and control bits 5:0 read as 0.
- R6: A port A latch read returns `pa_in` on all eight bits, whatever the direction.
- R7: A port B latch read returns the latch bit where the direction bit is 1 and the `pb_in` bit where it is 0.
- R8: `rsel` decode: 00 selects the port A latch or direction register, 01 control A, 10 the port B latch or direction register, and 11 control B.
- R9: Control bits 5:0 are written by the host. A control read returns `status_?[1:0]` on bits 7:6, and host writes to bits 7:6 have no effect.
- R10: A selected, enabled read at a port's shared address while its control bit 2 = 1 gives `rstb_?`=1 for exactly the following cycle. A read of the direction register, a control read and any write give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| rsel | input | 2 | Register address |
| rd_wr | input | 1 | 1 = read, 0 = write |
| en | input | 1 | Transfer enable strobe |
| host_wdata | input | 8 | Write data from host |
| host_rdata | output | 8 | Read data to host |
| host_rdata_oe | output | 1 | Host bus drive enable |
| status_a | input | 2 | Port A status flags for control bits 7:6 |
| status_b | input | 2 | Port B status flags for control bits 7:6 |
| pa_in | input | 8 | Port A pad levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-line output enable |
| pb_in | input | 8 | Port B pad levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-line output enable |
| rstb_a | output | 1 | Port A read strobe |
| rstb_b | output | 1 | Port B read strobe |

## Verification
The read strobe is registered, so it can fall in the same cycle as the next host transfer. The case that matters is a write that clears control bit 2 of the same port, issued back to back with the latch read.

The bench provokes this directly. It reads the port A latch, and in the very next cycle writes the control register. It checks three things:
- the strobe is high during that write cycle;
- the strobe is low afterwards;
- a following read of the shared address now returns the direction register and raises no strobe.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        RS_PORT_A = 2'b00,
        RS_CTL_A  = 2'b01,
        RS_PORT_B = 2'b10,
        RS_CTL_B  = 2'b11
    } rsel_e;
endpackage

// File: rtl/pp_decode.sv
module pp_decode (
    input  logic       cs_a,
    input  logic       cs_b,
    input  logic       cs_n,
    input  logic       en,
    input  logic       rd_wr,
    input  logic [1:0] rsel,
    output logic       rd_act,
    output logic       wr_port_a,
    output logic       wr_ctl_a,
    output logic       wr_port_b,
    output logic       wr_ctl_b,
    output logic       rd_port_a,
    output logic       rd_port_b
);
    import pp_pkg::*;

    logic sel;
    logic wr_act;

    always_comb begin
        sel       = cs_a && cs_b && !cs_n;
        rd_act    = sel && en && rd_wr;
        wr_act    = sel && en && !rd_wr;
        wr_port_a = wr_act && (rsel_e'(rsel) == RS_PORT_A);
        wr_ctl_a  = wr_act && (rsel_e'(rsel) == RS_CTL_A);
        wr_port_b = wr_act && (rsel_e'(rsel) == RS_PORT_B);
        wr_ctl_b  = wr_act && (rsel_e'(rsel) == RS_CTL_B);
        rd_port_a = rd_act && (rsel_e'(rsel) == RS_PORT_A);
        rd_port_b = rd_act && (rsel_e'(rsel) == RS_PORT_B);
    end
endmodule

// File: rtl/pp_port.sv
module pp_port #(
    parameter int DW        = 8,
    parameter int CTL_W     = 6,
    parameter int DSEL_BIT  = 2,
    parameter bit PIN_READ  = 1'b1,
    localparam int STAT_W   = DW - CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_port,
    input  logic              wr_ctl,
    input  logic              rd_port,
    input  logic [STAT_W-1:0] status,
    input  logic [DW-1:0]     pin_in,
    output logic [DW-1:0]     pin_out,
    output logic [DW-1:0]     pin_oe,
    output logic [DW-1:0]     port_rdata,
    output logic [DW-1:0]     ctl_rdata,
    output logic              rd_stb
);
    typedef struct packed {
        logic [DW-1:0]    dir;
        logic [DW-1:0]    lat;
        logic [CTL_W-1:0] ctl;
        logic             stb;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] lat_view;

    // Read source for the output latch location: pads or latch-on-outputs
    generate
        if (PIN_READ) begin : g_pin_read
            assign lat_view = pin_in;
        end else begin : g_latch_read
            assign lat_view = (st_q.lat & st_q.dir) | (pin_in & ~st_q.dir);
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.stb = rd_port && st_q.ctl[DSEL_BIT];
        if (wr_ctl) begin
            st_d.ctl = wr_data[CTL_W-1:0];
        end
        if (wr_port) begin
            if (st_q.ctl[DSEL_BIT]) begin
                st_d.lat = wr_data;
            end else begin
                st_d.dir = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out    = st_q.lat;
    assign pin_oe     = st_q.dir;
    assign port_rdata = st_q.ctl[DSEL_BIT] ? lat_view : st_q.dir;
    assign ctl_rdata  = {status, st_q.ctl};
    assign rd_stb     = st_q.stb;
endmodule

// File: rtl/par_port_slave.sv
module par_port_slave #(
    parameter int DW       = 8,
    parameter int CTL_W    = 6,
    parameter int DSEL_BIT = 2,
    localparam int STAT_W  = DW - CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a,
    input  logic              cs_b,
    input  logic              cs_n,
    input  logic [1:0]        rsel,
    input  logic              rd_wr,
    input  logic              en,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_rdata_oe,
    input  logic [STAT_W-1:0] status_a,
    input  logic [STAT_W-1:0] status_b,
    input  logic [DW-1:0]     pa_in,
    output logic [DW-1:0]     pa_out,
    output logic [DW-1:0]     pa_oe,
    input  logic [DW-1:0]     pb_in,
    output logic [DW-1:0]     pb_out,
    output logic [DW-1:0]     pb_oe,
    output logic              rstb_a,
    output logic              rstb_b
);
    import pp_pkg::*;

    logic rd_act;
    logic wr_port_a, wr_ctl_a, wr_port_b, wr_ctl_b;
    logic rd_port_a, rd_port_b;
    logic [DW-1:0] port_rd_a, port_rd_b, ctl_rd_a, ctl_rd_b;

    pp_decode u_dec (
        .cs_a      (cs_a),
        .cs_b      (cs_b),
        .cs_n      (cs_n),
        .en        (en),
        .rd_wr     (rd_wr),
        .rsel      (rsel),
        .rd_act    (rd_act),
        .wr_port_a (wr_port_a),
        .wr_ctl_a  (wr_ctl_a),
        .wr_port_b (wr_port_b),
        .wr_ctl_b  (wr_ctl_b),
        .rd_port_a (rd_port_a),
        .rd_port_b (rd_port_b)
    );

    pp_port #(.DW(DW), .CTL_W(CTL_W), .DSEL_BIT(DSEL_BIT), .PIN_READ(1'b1)) u_port_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (host_wdata),
        .wr_port    (wr_port_a),
        .wr_ctl     (wr_ctl_a),
        .rd_port    (rd_port_a),
        .status     (status_a),
        .pin_in     (pa_in),
        .pin_out    (pa_out),
        .pin_oe     (pa_oe),
        .port_rdata (port_rd_a),
        .ctl_rdata  (ctl_rd_a),
        .rd_stb     (rstb_a)
    );

    pp_port #(.DW(DW), .CTL_W(CTL_W), .DSEL_BIT(DSEL_BIT), .PIN_READ(1'b0)) u_port_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (host_wdata),
        .wr_port    (wr_port_b),
        .wr_ctl     (wr_ctl_b),
        .rd_port    (rd_port_b),
        .status     (status_b),
        .pin_in     (pb_in),
        .pin_out    (pb_out),
        .pin_oe     (pb_oe),
        .port_rdata (port_rd_b),
        .ctl_rdata  (ctl_rd_b),
        .rd_stb     (rstb_b)
    );

    always_comb begin
        unique case (rsel_e'(rsel))
            RS_PORT_A: host_rdata = port_rd_a;
            RS_CTL_A:  host_rdata = ctl_rd_a;
            RS_PORT_B: host_rdata = port_rd_b;
            default:   host_rdata = ctl_rd_b;
        endcase
    end

    assign host_rdata_oe = rd_act;
endmodule

// File: rtl/par_port_slave_sva.sv
module par_port_slave_sva #(
    parameter int DW     = 8,
    parameter int STAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_a,
    input logic              cs_b,
    input logic              cs_n,
    input logic [1:0]        rsel,
    input logic              rd_wr,
    input logic              en,
    input logic [DW-1:0]     host_rdata,
    input logic              host_rdata_oe,
    input logic [STAT_W-1:0] status_a,
    input logic [DW-1:0]     pa_out,
    input logic [DW-1:0]     pb_oe,
    input logic              rstb_a
);
    // R2
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata_oe |-> (en && rd_wr && cs_a && cs_b && !cs_n));

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_a && cs_b && !cs_n) |-> !host_rdata_oe);

    // R2
    pa_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pa_out) |-> $past(en && !rd_wr && cs_a && cs_b && !cs_n && rsel == 2'b00));

    // R3
    pb_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pb_oe) |-> $past(en && !rd_wr && cs_a && cs_b && !cs_n && rsel == 2'b10));

    // R10
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rstb_a |-> $past(en && rd_wr && cs_a && cs_b && !cs_n && rsel == 2'b00));

    // R9
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata_oe && rsel == 2'b01) |-> (host_rdata[DW-1 -: STAT_W] == status_a));
endmodule

bind par_port_slave par_port_slave_sva #(.DW(DW), .STAT_W(STAT_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_a          (cs_a),
    .cs_b          (cs_b),
    .cs_n          (cs_n),
    .rsel          (rsel),
    .rd_wr         (rd_wr),
    .en            (en),
    .host_rdata    (host_rdata),
    .host_rdata_oe (host_rdata_oe),
    .status_a      (status_a),
    .pa_out        (pa_out),
    .pb_oe         (pb_oe),
    .rstb_a        (rstb_a)
);

// File: tb/par_port_slave_tb.sv
module par_port_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_a = 1'b1, cs_b = 1'b1, cs_n = 1'b0;
    logic [1:0] rsel = 2'b00;
    logic       rd_wr = 1'b1;
    logic       en = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_rdata_oe;
    logic [1:0] status_a = 2'b00, status_b = 2'b00;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic       rstb_a, rstb_b;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd_val;
    logic       rd_oe;

    always #10 clk = ~clk;

    par_port_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .cs_n(cs_n),
        .rsel(rsel), .rd_wr(rd_wr), .en(en), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .status_a(status_a), .status_b(status_b),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .rstb_a(rstb_a), .rstb_b(rstb_b)
    );

    // vector: {is_read, rsel, wdata, pa_in, pb_in, expected read}
    localparam int NV = 16;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'hFF, 8'h00, 8'h00, 8'h00},  // R4 dir A = FF (bit2=0)
        {1'b0, 2'd1, 8'h04, 8'h00, 8'h00, 8'h00},  // R8 ctl A bit2=1
        {1'b0, 2'd0, 8'hA5, 8'h00, 8'h00, 8'h00},  // R4 latch A
        {1'b1, 2'd0, 8'h00, 8'h3C, 8'h00, 8'h3C},  // R6 pins, not latch
        {1'b1, 2'd0, 8'h00, 8'hE1, 8'h00, 8'hE1},  // R6 second pattern
        {1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h84},  // R9 status A=10
        {1'b0, 2'd2, 8'h0F, 8'h00, 8'h00, 8'h00},  // R8 dir B = 0F
        {1'b0, 2'd3, 8'h04, 8'h00, 8'h00, 8'h00},  // R8 ctl B bit2=1
        {1'b0, 2'd2, 8'h5A, 8'h00, 8'h00, 8'h00},  // latch B
        {1'b1, 2'd2, 8'h00, 8'h00, 8'hC3, 8'hCA},  // R7 latch on outs
        {1'b1, 2'd2, 8'h00, 8'h00, 8'h35, 8'h3A},  // R7 second pattern
        {1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h44},  // R9 status B=01
        {1'b0, 2'd3, 8'hFB, 8'h00, 8'h00, 8'h00},  // R9 write top bits
        {1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h7B},  // R9 top bits kept
        {1'b1, 2'd2, 8'h00, 8'h00, 8'hFF, 8'h0F},  // R4 dir view
        {1'b0, 2'd3, 8'h04, 8'h00, 8'h00, 8'h00}   // restore bit2
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the transfer edge
    task automatic xfer(input logic rd, input logic [1:0] rs, input logic [7:0] wd);
        rd_wr      = rd;
        rsel       = rs;
        host_wdata = wd;
        en         = 1'b1;
        #5;
        rd_val = host_rdata;
        rd_oe  = host_rdata_oe;
        @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5 reset state
        check("R5 pa_oe", pa_oe, 8'h00);
        check("R5 pb_oe", pb_oe, 8'h00);
        check("R5 pa_out", pa_out, 8'h00);
        check("R5 pb_out", pb_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle bus", {7'd0, host_rdata_oe}, 8'h00);
        xfer(1'b1, 2'd1, 8'h00);
        check("R5 ctl A", rd_val, 8'h00);
        check("R2 read drive", {7'd0, rd_oe}, 8'h01);

        status_a = 2'b10;
        status_b = 2'b01;
        for (int i = 0; i < NV; i++) begin
            pa_in = VEC[i][23:16];
            pb_in = VEC[i][15:8];
            xfer(VEC[i][34], VEC[i][33:32], VEC[i][31:24]);
            if (VEC[i][34]) check($sformatf("R8 vec%0d", i), rd_val, VEC[i][7:0]);
        end
        // R3 pins follow direction and latch
        check("R3 pa_oe", pa_oe, 8'hFF);
        check("R3 pa_out", pa_out, 8'hA5);
        check("R3 pb_oe", pb_oe, 8'h0F);
        check("R3 pb_out", pb_out, 8'h5A);

        // R1 deselected write ignored, read not driven
        cs_b = 1'b0;
        xfer(1'b0, 2'd0, 8'h11);
        check("R1 cs_b low write", pa_out, 8'hA5);
        cs_b = 1'b1; cs_n = 1'b1;
        xfer(1'b0, 2'd2, 8'h22);
        check("R1 cs_n high write", pb_out, 8'h5A);
        xfer(1'b1, 2'd0, 8'h00);
        check("R1 desel read oe", {7'd0, rd_oe}, 8'h00);
        check("R10 desel no strobe", {7'd0, rstb_a}, 8'h00);
        cs_n = 1'b0;

        // R2 enable low: no write
        rd_wr = 1'b0; rsel = 2'd0; host_wdata = 8'h33;
        @(negedge clk);
        check("R2 no enable", pa_out, 8'hA5);

        // R10 strobe after latch read, overlapping a control write
        xfer(1'b1, 2'd0, 8'h00);
        check("R10 strobe A high", {7'd0, rstb_a}, 8'h01);
        check("R10 strobe B quiet", {7'd0, rstb_b}, 8'h00);
        rd_wr = 1'b0; rsel = 2'd1; host_wdata = 8'h00; en = 1'b1;
        #5;
        check("R10 strobe during write", {7'd0, rstb_a}, 8'h01);
        @(negedge clk);
        en = 1'b0;
        check("R10 strobe one cycle", {7'd0, rstb_a}, 8'h00);
        xfer(1'b1, 2'd0, 8'h00);
        check("R4 dir after clear", rd_val, 8'hFF);
        check("R10 no strobe dir read", {7'd0, rstb_a}, 8'h00);
        xfer(1'b1, 2'd1, 8'h00);
        check("R10 no strobe ctl read", {7'd0, rstb_a}, 8'h00);
        xfer(1'b1, 2'd2, 8'h00);
        check("R10 strobe B", {7'd0, rstb_b}, 8'h01);

        // R5 reset mid-run
        rst_n = 1'b0;
        #2;
        check("R5 async pa_oe", pa_oe, 8'h00);
        check("R5 async pb_out", pb_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        status_b = 2'b00;
        xfer(1'b1, 2'd3, 8'h00);
        check("R5 ctl B cleared", rd_val, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule